// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer that sits on a simple register bus. The input clock is slowed in two stages: a programmable prescaler divides it by an 8-bit field plus one, and a selectable power-of-two divider then divides it by 16, 32, 64 or 128. Each slowed tick decrements a 16-bit down counter.

When a tick finds the counter at zero, the timer has expired. Expiry can raise a level interrupt, start a fixed-length system reset pulse, or do both, each under its own enable bit. The counter then reloads from a separate reload register and keeps running, so the same block also works as a periodic interrupt source.

Software keeps the system alive by writing the count register before the timeout elapses. That write also clears a pending interrupt. After reset the timer is already running with the reset action armed. This lets a boot that hangs recover without any help from software.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control register reads 0x8039 (prescale 0x80, divide-by-128, running, reset action on, interrupt off), the reload and count registers read 0x8000, and both the interrupt and reset outputs are low.
- R2: Word address 0 is the control register, address 1 the reload register, address 2 the count register, and address 3 reads zero. The control layout is: prescale in bits [15:8], run enable in bit 5, divider select in bits [4:3], interrupt enable in bit 2, reset enable in bit 0. Bits 7, 6 and 1 read zero. A write takes effect at the clock edge where bus_sel and bus_wr are both high. A read is combinational.
- R3: A running timer ticks every (prescale+1)·2^(4+select) clocks, and each tick lowers the count by one. A write to the control register or to the count register restarts the tick phase, so the first tick comes one full period after that write.
- R4: A tick that finds the count at zero is an expiry, and it loads the count from the reload register. A count of N written to the count register therefore expires (N+1) tick periods after the write, and expires again every (N+1) periods after that for as long as nobody writes the count register.
- R5: On an expiry with interrupt enable set, the interrupt output goes high on the next clock. It stays high until the count register is written. With interrupt enable clear, an expiry leaves the interrupt low.
- R6: On an expiry with reset enable set, the reset output is high for exactly RST_PULSE clocks (128 by default), starting on the next clock. With reset enable clear, an expiry leaves the reset output low.
- R7: With the run enable clear, the count holds its value, no expiry occurs and neither output rises.
- R8: A write to the count register loads the written value at once, readable on the next cycle. Writing it periodically, faster than the timeout, keeps the reset output low indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, also the timer source |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| wdt_irq | output | 1 | Expiry interrupt, a level held until keepalive |
| wdt_rst | output | 1 | System reset pulse |

## Verification
A fault in the prescaler or divider chain appears as a timeout that lands on the wrong clock. An expiry that arrives one clock early or late shows up within a single timeout. A wrong count or reload value shows up at the first tick, as a wrong count readback, or at the second expiry, as a wrong period. Faults in the pulse counter or the interrupt latch show up as a reset width other than RST_PULSE, or as an interrupt that drops before keepalive. The sweeps cover every prescale and select pairing of a small prescale range at several counts, so a fault in any of these paths is seen within about two thousand clocks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // register word addresses; software depends on these values
   typedef enum logic [1:0] {
      REG_CTRL   = 2'd0,
      REG_RELOAD = 2'd1,
      REG_COUNT  = 2'd2,
      REG_NONE   = 2'd3
   } wdt_reg_e;

   // fixed low control bit positions; the divider select and the run bit follow
   localparam int CTRL_RST_EN_BIT = 0;
   localparam int CTRL_IRQ_EN_BIT = 2;
   localparam int CTRL_SEL_LSB    = 3;

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int PRE_W   = 8,
   parameter int SEL_W   = 2,
   parameter int PRE_RST = 128,
   parameter int SEL_RST = 3,
   parameter int CNT_RST = 32768
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [1:0]       bus_addr,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   input  logic [CNT_W-1:0] cnt_val,
   output logic             run_en,
   output logic             irq_en,
   output logic             rst_en,
   output logic [SEL_W-1:0] div_sel,
   output logic [PRE_W-1:0] prescale,
   output logic [CNT_W-1:0] reload,
   output logic             ctrl_wr,
   output logic             cnt_wr
);

   localparam int PRE_LSB = CNT_W - PRE_W;
   localparam int RUN_BIT = CTRL_SEL_LSB + SEL_W;

   generate
      if (RUN_BIT >= PRE_LSB) begin : g_bad_layout
         $error("wdt_regs: prescale field overlaps the low control bits");
      end
   endgenerate

   wdt_reg_e     reg_sel;
   logic         wr_hit;
   logic [CNT_W-1:0] ctrl_rd;

   assign reg_sel = wdt_reg_e'(bus_addr);
   assign wr_hit  = bus_sel & bus_wr;
   assign ctrl_wr = wr_hit & (reg_sel == REG_CTRL);
   assign cnt_wr  = wr_hit & (reg_sel == REG_COUNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prescale <= PRE_W'(PRE_RST);
         div_sel  <= SEL_W'(SEL_RST);
         run_en   <= 1'b1;
         irq_en   <= 1'b0;
         rst_en   <= 1'b1;
      end else if (ctrl_wr) begin
         prescale <= bus_wdata[PRE_LSB +: PRE_W];
         div_sel  <= bus_wdata[CTRL_SEL_LSB +: SEL_W];
         run_en   <= bus_wdata[RUN_BIT];
         irq_en   <= bus_wdata[CTRL_IRQ_EN_BIT];
         rst_en   <= bus_wdata[CTRL_RST_EN_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload <= CNT_W'(CNT_RST);
      end else if (wr_hit && reg_sel == REG_RELOAD) begin
         reload <= bus_wdata;
      end
   end

   always_comb begin
      ctrl_rd = '0;
      ctrl_rd[PRE_LSB +: PRE_W]      = prescale;
      ctrl_rd[RUN_BIT]               = run_en;
      ctrl_rd[CTRL_SEL_LSB +: SEL_W] = div_sel;
      ctrl_rd[CTRL_IRQ_EN_BIT]       = irq_en;
      ctrl_rd[CTRL_RST_EN_BIT]       = rst_en;
   end

   always_comb begin
      case (reg_sel)
         REG_CTRL:   bus_rdata = ctrl_rd;
         REG_RELOAD: bus_rdata = reload;
         REG_COUNT:  bus_rdata = cnt_val;
         default:    bus_rdata = '0;
      endcase
   end

   // R2: a control write lands in the readable fields on the next cycle
   assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (prescale == $past(bus_wdata[PRE_LSB +: PRE_W])) &&
                  (run_en == $past(bus_wdata[RUN_BIT])));

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int PRE_W        = 8,
   parameter int DIV_BASE_LOG = 4,
   parameter int DIV_STEPS    = 4,
   parameter int SEL_W        = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             restart,
   input  logic [PRE_W-1:0] prescale,
   input  logic [SEL_W-1:0] div_sel,
   output logic             tick
);

   localparam int DIV_W = DIV_BASE_LOG + DIV_STEPS - 1;

   generate
      if (DIV_BASE_LOG < 1) begin : g_bad_base
         $error("wdt_prescaler: DIV_BASE_LOG must be at least 1");
      end
      if ((1 << SEL_W) < DIV_STEPS) begin : g_bad_sel
         $error("wdt_prescaler: SEL_W too narrow for DIV_STEPS");
      end
   endgenerate

   logic [PRE_W-1:0]     pre_cnt;
   logic                 pre_hit;
   logic [DIV_W-1:0]     div_cnt;
   logic [DIV_STEPS-1:0] wrap;
   logic                 wrap_sel;

   assign pre_hit = run_en & (pre_cnt == prescale);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt <= '0;
      end else if (!run_en || restart || pre_hit) begin
         pre_cnt <= '0;
      end else begin
         pre_cnt <= pre_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt <= '0;
      end else if (!run_en || restart) begin
         div_cnt <= '0;
      end else if (pre_hit) begin
         div_cnt <= div_cnt + 1'b1;
      end
   end

   // one terminal-count detector per divider setting
   generate
      for (genvar g = 0; g < DIV_STEPS; g++) begin : g_wrap
         assign wrap[g] = &div_cnt[DIV_BASE_LOG+g-1:0];
      end
   endgenerate

   always_comb begin
      wrap_sel = 1'b0;
      for (int i = 0; i < DIV_STEPS; i++) begin
         if (div_sel == SEL_W'(i)) wrap_sel = wrap[i];
      end
   end

   assign tick = pre_hit & wrap_sel & ~restart;

   // R3: the prescale phase never runs past the programmed limit
   assert_pre_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pre_cnt <= prescale);

   // R3: a restart zeroes the phase of both stages
   assert_restart_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (pre_cnt == '0) && (div_cnt == '0));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int CNT_W   = 16,
   parameter int CNT_RST = 32768
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);

   logic at_zero;

   assign at_zero = (cnt == '0);
   assign expire  = tick & at_zero & ~load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= CNT_W'(CNT_RST);
      end else if (load) begin
         cnt <= load_val;
      end else if (expire) begin
         cnt <= reload;
      end else if (tick) begin
         cnt <= cnt - 1'b1;
      end
   end

   // R8: keepalive write value is visible on the next cycle
   assert_keepalive_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt == $past(load_val));

   // R3: a tick on a non-zero count steps down by one
   assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && !at_zero) |=> cnt == $past(cnt) - 1'b1);

   // R4: expiry reloads from the reload register
   assert_expire_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> cnt == $past(reload));

endmodule

// File: rtl/wdt_alarm.sv
module wdt_alarm #(
   parameter int RST_PULSE = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic irq_en,
   input  logic rst_en,
   input  logic clear,
   output logic irq_o,
   output logic rst_o
);

   localparam int PW = $clog2(RST_PULSE + 1);

   generate
      if (RST_PULSE < 1) begin : g_bad_pulse
         $error("wdt_alarm: RST_PULSE must be at least 1");
      end
   endgenerate

   logic [PW-1:0] pulse_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o <= 1'b0;
      end else if (clear) begin
         irq_o <= 1'b0;
      end else if (expire && irq_en) begin
         irq_o <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_cnt <= '0;
      end else if (expire && rst_en) begin
         pulse_cnt <= PW'(RST_PULSE);
      end else if (pulse_cnt != '0) begin
         pulse_cnt <= pulse_cnt - 1'b1;
      end
   end

   assign rst_o = (pulse_cnt != '0);

   // R5: enabled expiry raises the interrupt
   assert_irq_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && irq_en && !clear) |=> irq_o);

   // R5: the interrupt level holds until keepalive
   assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !clear) |=> irq_o);

   // R5: no interrupt without an enabled expiry
   assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_o && !(expire && irq_en)) |=> !irq_o);

   // R6: enabled expiry starts the reset pulse
   assert_rst_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && rst_en) |=> rst_o);

   // R6: the reset pulse only begins on an enabled expiry
   assert_rst_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_o && !(expire && rst_en)) |=> !rst_o);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
   import wdt_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int PRE_W        = 8,
   parameter int DIV_BASE_LOG = 4,
   parameter int DIV_STEPS    = 4,
   parameter int RST_PULSE    = 128,
   parameter int PRE_RST      = 128,
   parameter int CNT_RST      = 32768
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [1:0]       bus_addr,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   output logic             wdt_irq,
   output logic             wdt_rst
);

   localparam int SEL_W   = (DIV_STEPS > 1) ? $clog2(DIV_STEPS) : 1;
   localparam int SEL_RST = DIV_STEPS - 1;

   generate
      if (DIV_STEPS < 1) begin : g_bad_steps
         $error("wdog_timer: DIV_STEPS must be at least 1");
      end
      if (CNT_RST >= (1 << CNT_W)) begin : g_bad_cnt_rst
         $error("wdog_timer: CNT_RST does not fit the counter");
      end
   endgenerate

   logic             run_en;
   logic             irq_en;
   logic             rst_en;
   logic [SEL_W-1:0] div_sel;
   logic [PRE_W-1:0] prescale;
   logic [CNT_W-1:0] reload;
   logic [CNT_W-1:0] cnt_val;
   logic             ctrl_wr;
   logic             cnt_wr;
   logic             tick;
   logic             expire;

   wdt_regs #(
      .CNT_W   (CNT_W),
      .PRE_W   (PRE_W),
      .SEL_W   (SEL_W),
      .PRE_RST (PRE_RST),
      .SEL_RST (SEL_RST),
      .CNT_RST (CNT_RST)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cnt_val   (cnt_val),
      .run_en    (run_en),
      .irq_en    (irq_en),
      .rst_en    (rst_en),
      .div_sel   (div_sel),
      .prescale  (prescale),
      .reload    (reload),
      .ctrl_wr   (ctrl_wr),
      .cnt_wr    (cnt_wr)
   );

   wdt_prescaler #(
      .PRE_W        (PRE_W),
      .DIV_BASE_LOG (DIV_BASE_LOG),
      .DIV_STEPS    (DIV_STEPS),
      .SEL_W        (SEL_W)
   ) u_prescaler (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (run_en),
      .restart  (ctrl_wr | cnt_wr),
      .prescale (prescale),
      .div_sel  (div_sel),
      .tick     (tick)
   );

   wdt_counter #(
      .CNT_W   (CNT_W),
      .CNT_RST (CNT_RST)
   ) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (cnt_wr),
      .load_val (bus_wdata),
      .reload   (reload),
      .cnt      (cnt_val),
      .expire   (expire)
   );

   wdt_alarm #(
      .RST_PULSE (RST_PULSE)
   ) u_alarm (
      .clk    (clk),
      .rst_n  (rst_n),
      .expire (expire),
      .irq_en (irq_en),
      .rst_en (rst_en),
      .clear  (cnt_wr),
      .irq_o  (wdt_irq),
      .rst_o  (wdt_rst)
   );

   // R7: a stopped timer keeps its count unless software loads it
   assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !cnt_wr) |=> $stable(cnt_val));

   // R7: a stopped timer never expires
   assert_no_expire_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |-> !expire);

endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;

   localparam int CLK_PERIOD = 10;
   localparam int RST_PULSE  = 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [15:0] bus_wdata = 16'h0;
   logic [15:0] bus_rdata;
   logic        wdt_irq;
   logic        wdt_rst;

   int n_cmp = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdog_timer u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .wdt_irq   (wdt_irq),
      .wdt_rst   (wdt_rst)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // control word per R2 layout
   function automatic logic [15:0] mk_ctrl(input int p, input int d, input bit en,
                                           input bit ie, input bit re);
      return {p[7:0], 2'b00, en, d[1:0], ie, 1'b0, re};
   endfunction

   // drive at a falling edge, returns at the falling edge after the write edge
   task automatic bus_write(input logic [1:0] a, input logic [15:0] v);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [15:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic stop_timer();
      bus_write(2'd0, mk_ctrl(0, 0, 1'b0, 1'b0, 1'b0));
      bus_write(2'd2, 16'h0);
   endtask

   // interrupt mode: timeout, first tick, reload, hold and clear
   task automatic run_irq_case(input int p, input int d, input int n);
      int t;
      int expv;
      int m;
      logic [15:0] rv;
      bit tick_seen;
      t = (p + 1) << (4 + d);
      expv = (n + 1) * t;
      bus_write(2'd0, mk_ctrl(p, d, 1'b1, 1'b1, 1'b0));
      bus_write(2'd1, 16'(n));
      bus_write(2'd2, 16'(n));
      m = 0;
      tick_seen = 1'b0;
      while (!wdt_irq && m < expv + 8) begin
         @(negedge clk);
         m++;
         if (m == t && n > 0) begin
            bus_read(2'd2, rv);
            chk("R3 count after first tick", rv, 16'(n - 1));
            tick_seen = 1'b1;
         end
      end
      chk($sformatf("R4 timeout p=%0d d=%0d n=%0d", p, d, n), m, expv);
      bus_read(2'd2, rv);
      chk("R4 reloaded count", rv, 16'(n));
      chk("R6 no reset pulse with reset enable clear", wdt_rst, 1'b0);
      repeat (t + 3) @(negedge clk);
      chk("R5 interrupt held", wdt_irq, 1'b1);
      bus_write(2'd2, 16'(n));
      chk("R5 interrupt cleared by count write", wdt_irq, 1'b0);
      stop_timer();
   endtask

   // reset mode: timeout, pulse width, periodic re-expiry
   task automatic run_rst_case(input int p, input int n);
      int t;
      int expv;
      int m;
      int w;
      bit irq_seen;
      t = (p + 1) << 7;
      expv = (n + 1) * t;
      bus_write(2'd0, mk_ctrl(p, 3, 1'b1, 1'b0, 1'b1));
      bus_write(2'd1, 16'(n));
      bus_write(2'd2, 16'(n));
      m = 0;
      irq_seen = 1'b0;
      while (!wdt_rst && m < expv + 8) begin
         @(negedge clk);
         m++;
         irq_seen |= wdt_irq;
      end
      chk($sformatf("R6 reset start p=%0d n=%0d", p, n), m, expv);
      w = 0;
      while (wdt_rst && w < RST_PULSE + 8) begin
         @(negedge clk);
         w++;
         m++;
         irq_seen |= wdt_irq;
      end
      chk("R6 reset pulse width", w, RST_PULSE);
      while (!wdt_rst && m < 2 * expv + 8) begin
         @(negedge clk);
         m++;
         irq_seen |= wdt_irq;
      end
      chk("R4 periodic second expiry", m, 2 * expv);
      chk("R5 no interrupt with interrupt enable clear", irq_seen, 1'b0);
      stop_timer();
      repeat (RST_PULSE + 2) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_cmp++;
         n_err++;
         $display("FAIL watchdog: run did not finish, actual running expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
         $finish;
      end
   end

   initial begin
      logic [15:0] rv;
      bit rst_seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_read(2'd0, rv); chk("R1 control reset", rv, 16'h8039);
      bus_read(2'd1, rv); chk("R1 reload reset", rv, 16'h8000);
      bus_read(2'd2, rv); chk("R1 count reset", rv, 16'h8000);
      chk("R1 interrupt low", wdt_irq, 1'b0);
      chk("R1 reset low", wdt_rst, 1'b0);

      // R2 register map and reserved bits
      bus_write(2'd0, 16'hFFFF);
      bus_read(2'd0, rv); chk("R2 control reserved bits read zero", rv, 16'hFF3D);
      stop_timer();
      bus_write(2'd1, 16'h1234);
      bus_read(2'd1, rv); chk("R2 reload readback", rv, 16'h1234);
      bus_read(2'd3, rv); chk("R2 unused address reads zero", rv, 16'h0000);

      // R7 stopped timer holds its count
      bus_write(2'd0, mk_ctrl(0, 0, 1'b0, 1'b1, 1'b1));
      bus_write(2'd1, 16'h0000);
      bus_write(2'd2, 16'h0005);
      rst_seen = 1'b0;
      for (int i = 0; i < 1000; i++) begin
         @(negedge clk);
         rst_seen |= wdt_rst | wdt_irq;
      end
      bus_read(2'd2, rv); chk("R7 count frozen", rv, 16'h0005);
      chk("R7 no output while stopped", rst_seen, 1'b0);

      // R3 R4 R5 sweep in interrupt mode
      for (int p = 0; p < 4; p++) begin
         for (int d = 0; d < 4; d++) begin
            run_irq_case(p, d, 0);
            run_irq_case(p, d, 1);
            run_irq_case(p, d, 3);
         end
      end

      // R6 sweep in reset mode
      for (int p = 0; p < 4; p++) begin
         run_rst_case(p, 1);
         run_rst_case(p, 2);
      end

      // R8 keepalive prevents the reset
      bus_write(2'd0, mk_ctrl(0, 0, 1'b1, 1'b0, 1'b1));
      bus_write(2'd1, 16'd3);
      bus_write(2'd2, 16'd3);
      rst_seen = 1'b0;
      for (int k = 0; k < 20; k++) begin
         for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            rst_seen |= wdt_rst;
         end
         bus_write(2'd2, 16'd3);
         rst_seen |= wdt_rst;
      end
      chk("R8 keepalive holds reset off", rst_seen, 1'b0);
      bus_write(2'd2, 16'h0ABC);
      bus_read(2'd2, rv); chk("R8 count write loads at once", rv, 16'h0ABC);
      stop_timer();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
   end

endmodule